// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block holds a one-byte segment-select register and turns a CPU access inside a fixed 64 KiB aperture into a physical video-memory address. Reads and writes each have their own bank number, so software can copy data from one bank to another through the same aperture without reprogramming between cycles. The register is written and read back through one byte-wide I/O port. A mode-set strobe restores the power-on value.

A build-time parameter picks one of two register layouts. The wide layout has two 4-bit bank fields, giving 16 banks of 64 KiB. The narrow layout has two 3-bit bank fields and a granularity bit that selects 64 KiB or 128 KiB banks. In the narrow layout the top bit is kept and read back but has no effect on the address. Each accepted access returns one physical address, registered, on the next cycle. The address wraps at a power-of-two memory size given on an input.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset, `seg_rdata` reads 00h in the wide layout and 40h in the narrow layout, and `pa_valid` is 0.
- R2: Wide layout: bits 3:0 of the register are the write bank and bits 7:4 are the read bank. A port write takes effect on the next cycle, and `seg_rdata` then returns {read bank, write bank}, which equals the byte written.
- R3: Narrow layout: bits 2:0 are the write bank and bits 5:3 are the read bank. Bit 6 at 1 selects 64 KiB banks and bit 6 at 0 selects 128 KiB banks. Readback is rebuilt as {bit 7, granularity bit, read bank, write bank}.
- R4: Narrow layout: bit 7 is stored and read back but never changes the translated address.
- R5: When `mode_set` is 1, the register takes its reset value (00h wide, 40h narrow) on the next cycle, even if a port write comes in the same cycle.
- R6: An access with `acc_write`=1 uses the write bank. An access with `acc_write`=0 uses the read bank.
- R7: One cycle after `acc_valid`, `pa_valid` is 1 and `pa_addr` = bank × bank size + `acc_off`. A cycle with no access drives `pa_valid` to 0, and `pa_addr` keeps its last value.
- R8: The address is reduced modulo 2^`mem_size_log2`. Values of `mem_size_log2` at or above the address width cause no wrap.
- R9: An access in the same cycle as a port write is translated with the banks held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr | input | 1 | Write strobe for the segment-select register |
| seg_wdata | input | 8 | Data for the register write |
| seg_rdata | output | 8 | Register readback |
| mode_set | input | 1 | Restores the register to its reset value |
| mem_size_log2 | input | LOG_W (5) | Log2 of the memory size in bytes |
| acc_valid | input | 1 | CPU access inside the aperture |
| acc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| acc_off | input | OFF_W (16) | Byte offset inside the aperture |
| pa_valid | output | 1 | Translated address valid |
| pa_addr | output | PA_W (20) | Physical memory address |

## Verification
The bench runs a wide instance and a narrow instance side by side on the same stimulus. Each byte therefore tests two decodes: a swapped read/write field, or a granularity bit with the wrong sense, gives a wrong bank multiple in one of the two instances. It writes bytes that differ only in the narrow top bit and compares the two addresses, so a design that lets that bit leak into translation is caught. It fires `mode_set` together with a port write to catch wrong priority. It also overlaps an access with a register write to catch a design that translates with the new banks too early. Wrap checks use a high bank with sizes below, at and above the address width, which exposes an off-by-one mask or a mask that is missing.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    localparam int SEG_W  = 8;
    localparam int BANK_W = 4;

    // value loaded by reset and by a mode set
    function automatic logic [SEG_W-1:0] seg_init(input bit narrow);
        return narrow ? 8'h40 : 8'h00;
    endfunction
endpackage

// File: rtl/bwm_seg_decode.sv
module bwm_seg_decode
    import bwm_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic [SEG_W-1:0]  seg,
    output logic [BANK_W-1:0] wr_bank,
    output logic [BANK_W-1:0] rd_bank,
    output logic              big_bank,
    output logic [SEG_W-1:0]  readback
);
    generate
        if (NARROW) begin : g_narrow
            // 3-bit fields; bit 6 picks granularity; bit 7 only stored
            always_comb begin
                wr_bank  = {1'b0, seg[2:0]};
                rd_bank  = {1'b0, seg[5:3]};
                big_bank = ~seg[6];
                readback = {seg[7], ~big_bank, rd_bank[2:0], wr_bank[2:0]};
            end
        end else begin : g_wide
            always_comb begin
                wr_bank  = seg[3:0];
                rd_bank  = seg[7:4];
                big_bank = 1'b0;
                readback = {rd_bank, wr_bank};
            end
        end
    endgenerate
endmodule

// File: rtl/bwm_addr_calc.sv
module bwm_addr_calc
    import bwm_pkg::*;
#(
    parameter int PA_W  = 20,
    parameter int OFF_W = 16
) (
    input  logic [BANK_W-1:0] bank,
    input  logic              big_bank,
    input  logic [OFF_W-1:0]  off,
    output logic [PA_W-1:0]   sum
);
    logic [PA_W-1:0] bank_ext;
    logic [PA_W-1:0] base;

    always_comb begin
        bank_ext = PA_W'(bank);
        base     = big_bank ? (bank_ext << (OFF_W + 1)) : (bank_ext << OFF_W);
        sum      = base + PA_W'(off);
    end
endmodule

// File: rtl/bwm_wrap_mask.sv
module bwm_wrap_mask #(
    parameter int PA_W  = 20,
    parameter int LOG_W = 5
) (
    input  logic [LOG_W-1:0] size_log2,
    output logic [PA_W-1:0]  mask
);
    always_comb begin
        if (int'(size_log2) >= PA_W)
            mask = '1;
        else
            mask = (PA_W'(1) << size_log2) - PA_W'(1);
    end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
    import bwm_pkg::*;
#(
    parameter bit NARROW = 1'b0,
    parameter int PA_W   = 20,
    parameter int OFF_W  = 16,
    parameter int LOG_W  = $clog2(PA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr,
    input  logic [SEG_W-1:0]  seg_wdata,
    output logic [SEG_W-1:0]  seg_rdata,
    input  logic              mode_set,
    input  logic [LOG_W-1:0]  mem_size_log2,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFF_W-1:0]  acc_off,
    output logic              pa_valid,
    output logic [PA_W-1:0]   pa_addr
);
    localparam logic [SEG_W-1:0] SEG_RST = seg_init(NARROW);

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic             vld;
        logic [PA_W-1:0]  addr;
    } state_t;

    state_t st_d, st_q;

    logic [BANK_W-1:0] wr_bank, rd_bank, sel_bank;
    logic              big_bank;
    logic [PA_W-1:0]   raw_addr, size_mask;

    bwm_seg_decode #(.NARROW(NARROW)) u_dec (
        .seg      (st_q.seg),
        .wr_bank  (wr_bank),
        .rd_bank  (rd_bank),
        .big_bank (big_bank),
        .readback (seg_rdata)
    );

    assign sel_bank = acc_write ? wr_bank : rd_bank;

    bwm_addr_calc #(.PA_W(PA_W), .OFF_W(OFF_W)) u_calc (
        .bank     (sel_bank),
        .big_bank (big_bank),
        .off      (acc_off),
        .sum      (raw_addr)
    );

    bwm_wrap_mask #(.PA_W(PA_W), .LOG_W(LOG_W)) u_mask (
        .size_log2 (mem_size_log2),
        .mask      (size_mask)
    );

    always_comb begin
        st_d = st_q;
        if (mode_set)
            st_d.seg = SEG_RST;
        else if (seg_wr)
            st_d.seg = seg_wdata;
        st_d.vld = acc_valid;
        if (acc_valid)
            st_d.addr = raw_addr & size_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seg  <= SEG_RST;
            st_q.vld  <= 1'b0;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pa_valid = st_q.vld;
    assign pa_addr  = st_q.addr;
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
    parameter bit NARROW = 1'b0,
    parameter int PA_W   = 20,
    parameter int OFF_W  = 16,
    parameter int LOG_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_wr,
    input logic [7:0]       seg_wdata,
    input logic [7:0]       seg_rdata,
    input logic             mode_set,
    input logic [LOG_W-1:0] mem_size_log2,
    input logic             acc_valid,
    input logic [OFF_W-1:0] acc_off,
    input logic             pa_valid,
    input logic [PA_W-1:0]  pa_addr
);
    localparam logic [7:0] INIT_VAL = NARROW ? 8'h40 : 8'h00;

    // R2 / R3: a plain write reads back unchanged on the next cycle
    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr && !mode_set |=> seg_rdata == $past(seg_wdata));

    // R5: mode set wins and loads the init value
    p_mode_set_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_set |=> seg_rdata == INIT_VAL);

    // R7: valid follows the access by one cycle
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> pa_valid);
    p_idle_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !pa_valid && $stable(pa_addr));

    // R7: bank bases are 64 KiB multiples, so low bits carry the offset
    p_offset_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (int'(mem_size_log2) >= OFF_W)
        |=> pa_addr[OFF_W-1:0] == $past(acc_off));

    // R8: nothing at or above the memory size
    p_wrap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (int'(mem_size_log2) < PA_W)
        |=> (pa_addr >> $past(mem_size_log2)) == '0);

    // R2: register holds without a write or mode set
    p_seg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_wr && !mode_set |=> $stable(seg_rdata));
endmodule

bind bank_window_mapper bwm_checker #(
    .NARROW(NARROW), .PA_W(PA_W), .OFF_W(OFF_W), .LOG_W(LOG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .seg_wr(seg_wr), .seg_wdata(seg_wdata),
    .seg_rdata(seg_rdata), .mode_set(mode_set), .mem_size_log2(mem_size_log2),
    .acc_valid(acc_valid), .acc_off(acc_off), .pa_valid(pa_valid),
    .pa_addr(pa_addr)
);

// File: tb/sim_bank_window_mapper.sv
`timescale 1ns/1ps
module sim_bank_window_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr = 1'b0;
    logic [7:0]  seg_wdata = '0;
    logic        mode_set = 1'b0;
    logic [4:0]  mem_size_log2 = 5'd20;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_off = '0;
    logic [7:0]  rd_w, rd_n;
    logic        pv_w, pv_n;
    logic [19:0] pa_w, pa_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_window_mapper #(.NARROW(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .seg_wr(seg_wr), .seg_wdata(seg_wdata),
        .seg_rdata(rd_w), .mode_set(mode_set), .mem_size_log2(mem_size_log2),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_off(acc_off),
        .pa_valid(pv_w), .pa_addr(pa_w));

    bank_window_mapper #(.NARROW(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .seg_wr(seg_wr), .seg_wdata(seg_wdata),
        .seg_rdata(rd_n), .mode_set(mode_set), .mem_size_log2(mem_size_log2),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_off(acc_off),
        .pa_valid(pv_n), .pa_addr(pa_n));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected address from the requirement text
    function automatic int exp_pa(input bit narrow, input logic [7:0] seg,
                                  input bit wr, input logic [15:0] off,
                                  input int lg);
        longint bank, a;
        int sh;
        if (!narrow) begin
            bank = wr ? seg[3:0] : seg[7:4];
            sh = 16;
        end else begin
            bank = wr ? seg[2:0] : seg[5:3];
            sh = seg[6] ? 16 : 17;
        end
        a = (bank << sh) + longint'(off);
        if (lg < 20) a = a % (longint'(1) << lg);
        return int'(a & 64'hFFFFF);
    endfunction

    task automatic seg_write(input logic [7:0] v);
        @(negedge clk); seg_wr = 1'b1; seg_wdata = v;
        @(negedge clk); seg_wr = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [15:0] off);
        @(negedge clk); acc_valid = 1'b1; acc_write = wr; acc_off = off;
        @(negedge clk); acc_valid = 1'b0;
    endtask

    task automatic check_both(input string req, input logic [7:0] seg,
                              input bit wr, input logic [15:0] off);
        chk({req, " wide valid"}, pv_w, 1);
        chk({req, " wide addr"}, pa_w, exp_pa(1'b0, seg, wr, off, mem_size_log2));
        chk({req, " narrow valid"}, pv_n, 1);
        chk({req, " narrow addr"}, pa_n, exp_pa(1'b1, seg, wr, off, mem_size_log2));
    endtask

    task automatic t_reset();
        chk("R1 wide init", rd_w, 8'h00);
        chk("R1 narrow init", rd_n, 8'h40);
        chk("R1 wide valid", pv_w, 0);
        chk("R1 narrow valid", pv_n, 0);
    endtask

    task automatic t_fields();
        seg_write(8'hA5);
        chk("R2 wide readback", rd_w, 8'hA5);
        chk("R3 narrow readback", rd_n, 8'hA5);
        access(1'b1, 16'h1234);
        check_both("R6 write bank", 8'hA5, 1'b1, 16'h1234);
        access(1'b0, 16'hFFFF);
        check_both("R6 read bank", 8'hA5, 1'b0, 16'hFFFF);
        // R3: 64 KiB granularity in narrow
        seg_write(8'h5E);
        chk("R3 narrow readback 64k", rd_n, 8'h5E);
        access(1'b1, 16'h0010);
        check_both("R3 64k write", 8'h5E, 1'b1, 16'h0010);
        access(1'b0, 16'h8000);
        check_both("R3 64k read", 8'h5E, 1'b0, 16'h8000);
    endtask

    task automatic t_top_bit();
        int a0, a1;
        seg_write(8'h2B);
        access(1'b0, 16'h0042);
        a0 = pa_n;
        seg_write(8'hAB);
        chk("R4 bit7 readback", rd_n, 8'hAB);
        access(1'b0, 16'h0042);
        a1 = pa_n;
        chk("R4 bit7 no effect", a1, a0);
        chk("R4 bit7 value", a1, exp_pa(1'b1, 8'h2B, 1'b0, 16'h0042, 20));
    endtask

    task automatic t_mode_set();
        seg_write(8'hFF);
        @(negedge clk); mode_set = 1'b1; seg_wr = 1'b1; seg_wdata = 8'h77;
        @(negedge clk); mode_set = 1'b0; seg_wr = 1'b0;
        chk("R5 wide mode set", rd_w, 8'h00);
        chk("R5 narrow mode set", rd_n, 8'h40);
        access(1'b1, 16'h0F0F);
        check_both("R5 banks zero", 8'h40, 1'b1, 16'h0F0F);
    endtask

    task automatic t_idle();
        int held;
        access(1'b1, 16'h3333);
        held = pa_w;
        @(negedge clk);
        chk("R7 idle valid", pv_w, 0);
        chk("R7 idle hold", pa_w, held);
    endtask

    task automatic t_wrap();
        seg_write(8'hFF);
        mem_size_log2 = 5'd18;
        access(1'b1, 16'h1111);
        check_both("R8 wrap 256k", 8'hFF, 1'b1, 16'h1111);
        chk("R8 wrap value", pa_w, 20'h31111);
        mem_size_log2 = 5'd16;
        access(1'b0, 16'h2222);
        chk("R8 wrap 64k", pa_w, 20'h02222);
        mem_size_log2 = 5'd25;
        access(1'b1, 16'h4444);
        chk("R8 no wrap", pa_w, 20'hF4444);
        mem_size_log2 = 5'd20;
    endtask

    task automatic t_overlap();
        seg_write(8'h12);
        @(negedge clk);
        seg_wr = 1'b1; seg_wdata = 8'h34;
        acc_valid = 1'b1; acc_write = 1'b1; acc_off = 16'h0000;
        @(negedge clk); seg_wr = 1'b0; acc_valid = 1'b0;
        chk("R9 old bank wide", pa_w, 20'h20000);
        chk("R9 old bank narrow", pa_n, exp_pa(1'b1, 8'h12, 1'b1, 16'h0, 20));
        access(1'b1, 16'h0000);
        chk("R9 new bank wide", pa_w, 20'h40000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_top_bit();
        t_mode_set();
        t_idle();
        t_wrap();
        t_overlap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule